// File: doc/BRIEF.md
# Dual-width static memory with chip-select control decoding

This block is a synthesizable, cycle-based model of a small static memory that keeps the control semantics of an asynchronous part. The model has two chip selects of opposite polarity, an output enable, a read/write strobe, and a low and a high byte-lane enable. A width pin switches between 16-bit word access and 8-bit byte access. The bidirectional data bus is split into a data-in vector, a data-out vector and a per-bit drive-enable vector. The enclosing pad ring or bus fabric recombines them. A two-bit mode output reports what the decoded controls asked for in the cycle that was just sampled.

In word mode, each byte lane is read or written only when its enable is low. In byte mode, bit 15 of the data-in bus serves as the least significant address bit and picks the high or low half of the addressed word. Data then moves on bits 7..0 only. The array depth is a power-of-two parameter, and any address bits above the array index are ignored, so the address wraps.

Inputs are sampled on the rising clock edge. Writes commit at that edge, and the data, drive-enable and mode outputs are registered at that edge. The reset input is asynchronous and active low, and its release is synchronized inside the block.

Top module: `dwsram_ctl`

## Requirements
- R1: While reset is applied, `dq_oe` and `dq_out` are all zero and `mode_o` reads standby (0).
- R2: Unless `sel_n` is 0 and `sel_hi` is 1, the block is in standby: `mode_o` is 0, nothing is driven, and no write changes the array.
- R3: `mode_o` encodes standby=0, output-deselect=1, read=2, write=3. A selected read cycle with `oe_n` high gives output-deselect, with `dq_oe` all zero.
- R4: A word-mode read (`rd_wr_n`=1, `oe_n`=0) drives bits 7..0 when `lane_lo_n` is 0 and bits 15..8 when `lane_hi_n` is 0. Bits of a lane that is not enabled have `dq_oe` 0 and `dq_out` 0.
- R5: A word-mode write (`rd_wr_n`=0) stores only the lanes whose enable is low. The other byte of the word keeps its value.
- R6: In word mode, a selected cycle with both lane enables high is standby: no write takes place and no bit is driven.
- R7: A byte-mode write (`word_mode`=0) stores `dq_in[7:0]` into the high byte of the word when `dq_in[15]` is 1, and into the low byte when it is 0. The lane enables have no effect.
- R8: A byte-mode read returns the byte chosen by `dq_in[15]` on `dq_out[7:0]`, with `dq_oe` equal to 16'h00FF and `dq_out[15:8]` zero.
- R9: During a write cycle `mode_o` is 3 and `dq_oe` is zero, whatever the value of `oe_n`.
- R10: The word index is the address modulo DEPTH, so addresses that differ by a multiple of DEPTH name the same word.
- R11: Outputs for a cycle appear after the rising edge that samples its inputs. A write is visible to a read issued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| sel_hi | input | 1 | Chip select, active high |
| oe_n | input | 1 | Output enable, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| lane_lo_n | input | 1 | Low byte lane enable, active low (word mode) |
| lane_hi_n | input | 1 | High byte lane enable, active low (word mode) |
| word_mode | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data bus as seen into the block; bit 15 is the byte select in byte mode |
| dq_out | output | 16 | Data driven onto the bus |
| dq_oe | output | 16 | Per-bit drive enable for `dq_out` |
| mode_o | output | 2 | Decoded operating mode |

## Verification
Every result is due one clock after the edge that samples its stimulus. The mode, the data-out bits and the drive enables all come from the same register stage. A write therefore shows up in a read issued on the following cycle. The driver applies inputs on the falling edge and queues what the next rising edge must produce. The monitor pops one entry per cycle, 2 ns after that rising edge, so every comparison lands in the cycle where the output has just settled. Effects that have no output of their own, such as a write that must be suppressed, are checked by a later read of the same word through the data bus.

// File: rtl/dwsram_pkg.sv
package dwsram_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  typedef enum logic [1:0] {
    MODE_STANDBY  = 2'd0,
    MODE_DESELECT = 2'd1,
    MODE_READ     = 2'd2,
    MODE_WRITE    = 2'd3
  } mode_e;
endpackage

// File: rtl/dwsram_decode.sv
// Control decoder: chip select, direction, output enable and lane choice.
module dwsram_decode
  import dwsram_pkg::*;
(
  input  logic             sel_n,
  input  logic             sel_hi,
  input  logic             oe_n,
  input  logic             rd_wr_n,
  input  logic             lane_lo_n,
  input  logic             lane_hi_n,
  input  logic             word_mode,
  input  logic             byte_hi,
  output mode_e            mode,
  output logic [LANES-1:0] lane_en
);
  logic selected;
  logic [LANES-1:0] lane_req;

  always_comb begin
    selected = !sel_n && sel_hi;
    if (word_mode) begin
      lane_req = {!lane_hi_n, !lane_lo_n};
    end else begin
      lane_req = byte_hi ? 2'b10 : 2'b01;
    end
    mode = MODE_STANDBY;
    if (selected && (lane_req != '0)) begin
      if (!rd_wr_n) begin
        mode = MODE_WRITE;
      end else if (oe_n) begin
        mode = MODE_DESELECT;
      end else begin
        mode = MODE_READ;
      end
    end
    lane_en = lane_req;
  end
endmodule

// File: rtl/dwsram_array.sv
// Storage: one byte-wide bank per lane, each with its own write enable.
module dwsram_array
  import dwsram_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [LANES-1:0]  wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en[g]) begin
        bank[idx] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = bank[idx];
  end
endmodule

// File: rtl/dwsram_rdpath.sv
// Read steering: lane masking in word mode, byte selection in byte mode.
module dwsram_rdpath
  import dwsram_pkg::*;
(
  input  mode_e             mode,
  input  logic              word_mode,
  input  logic              byte_hi,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dout_nxt,
  output logic [DATA_W-1:0] doe_nxt
);
  always_comb begin
    dout_nxt = '0;
    doe_nxt  = '0;
    if (mode == MODE_READ) begin
      if (word_mode) begin
        for (int l = 0; l < LANES; l++) begin
          if (lane_en[l]) begin
            dout_nxt[l*LANE_W +: LANE_W] = rdata[l*LANE_W +: LANE_W];
            doe_nxt[l*LANE_W +: LANE_W]  = '1;
          end
        end
      end else begin
        dout_nxt[LANE_W-1:0] = byte_hi ? rdata[DATA_W-1 -: LANE_W]
                                       : rdata[LANE_W-1:0];
        doe_nxt[LANE_W-1:0]  = '1;
      end
    end
  end
endmodule

// File: rtl/dwsram_ctl.sv
// Top: reset synchronizer, decode, array, read steering and output registers.
module dwsram_ctl
  import dwsram_pkg::*;
#(
  parameter int DEPTH      = 256,
  parameter int ADDR_W     = 19,
  parameter int RST_STAGES = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              oe_n,
  input  logic              rd_wr_n,
  input  logic              lane_lo_n,
  input  logic              lane_hi_n,
  input  logic              word_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic [15:0]       dq_oe,
  output logic [1:0]        mode_o
);
  // Reset: asserted at once, released after RST_STAGES clock edges.
  logic rst_int_n;
  if (RST_STAGES > 1) begin : g_rst_chain
    logic [RST_STAGES-1:0] rst_pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_pipe <= '0;
      else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
    end
    assign rst_int_n = rst_pipe[RST_STAGES-1];
  end else begin : g_rst_single
    logic rst_ff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_ff <= 1'b0;
      else        rst_ff <= 1'b1;
    end
    assign rst_int_n = rst_ff;
  end

  logic              byte_hi;
  logic [IDX_W-1:0]  idx;
  logic              unused_addr_hi;
  mode_e             mode_d;
  logic [LANES-1:0]  lane_en;
  logic [LANES-1:0]  wr_en;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic [DATA_W-1:0] dout_nxt;
  logic [DATA_W-1:0] doe_nxt;

  assign byte_hi = dq_in[DATA_W-1];
  assign idx     = addr[IDX_W-1:0];

  if (ADDR_W > IDX_W) begin : g_addr_wrap
    assign unused_addr_hi = ^addr[ADDR_W-1:IDX_W];
  end else begin : g_addr_exact
    assign unused_addr_hi = 1'b0;
  end

  dwsram_decode u_decode (
    .sel_n     (sel_n),
    .sel_hi    (sel_hi),
    .oe_n      (oe_n),
    .rd_wr_n   (rd_wr_n),
    .lane_lo_n (lane_lo_n),
    .lane_hi_n (lane_hi_n),
    .word_mode (word_mode),
    .byte_hi   (byte_hi),
    .mode      (mode_d),
    .lane_en   (lane_en)
  );

  always_comb begin
    wr_en = (mode_d == MODE_WRITE) ? lane_en : '0;
    if (word_mode) wdata = dq_in;
    else           wdata = {LANES{dq_in[LANE_W-1:0]}};
  end

  dwsram_array #(.DEPTH(DEPTH)) u_array (
    .clk   (clk),
    .wr_en (wr_en),
    .idx   (idx),
    .wdata (wdata),
    .rdata (rdata)
  );

  dwsram_rdpath u_rdpath (
    .mode      (mode_d),
    .word_mode (word_mode),
    .byte_hi   (byte_hi),
    .lane_en   (lane_en),
    .rdata     (rdata),
    .dout_nxt  (dout_nxt),
    .doe_nxt   (doe_nxt)
  );

  // Output registers
  mode_e             mode_q;
  logic [DATA_W-1:0] dout_q;
  logic [DATA_W-1:0] doe_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q <= MODE_STANDBY;
      dout_q <= '0;
      doe_q  <= '0;
    end else begin
      mode_q <= mode_d;
      dout_q <= dout_nxt;
      doe_q  <= doe_nxt;
    end
  end

  assign dq_out = dout_q;
  assign dq_oe  = doe_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/dwsram_chk.sv
// Property checker, bound into the top module.
module dwsram_chk (
  input logic        clk,
  input logic        rst_int_n,
  input logic        sel_n,
  input logic        sel_hi,
  input logic        oe_n,
  input logic        rd_wr_n,
  input logic        lane_lo_n,
  input logic        lane_hi_n,
  input logic        word_mode,
  input logic [15:0] dq_oe,
  input logic [1:0]  mode_o
);
  logic sel;
  logic any_lane;
  assign sel      = !sel_n && sel_hi;
  assign any_lane = !word_mode || !lane_lo_n || !lane_hi_n;

  assert_unselected_standby_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel_n || !sel_hi) |=> (mode_o == 2'd0 && dq_oe == 16'h0000));

  assert_deselect_quiet_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel && rd_wr_n && oe_n && any_lane) |=> (mode_o == 2'd1 && dq_oe == 16'h0000));

  assert_drive_only_in_read_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_o != 2'd2) |-> (dq_oe == 16'h0000));

  assert_read_both_lanes_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel && rd_wr_n && !oe_n && word_mode && !lane_lo_n && !lane_hi_n) |=> (dq_oe == 16'hFFFF));

  assert_read_low_lane_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel && rd_wr_n && !oe_n && word_mode && !lane_lo_n && lane_hi_n) |=> (dq_oe == 16'h00FF));

  assert_no_lane_standby_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (word_mode && lane_lo_n && lane_hi_n) |=> (mode_o == 2'd0));

  assert_byte_mode_upper_quiet_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!word_mode) |=> (dq_oe[15:8] == 8'h00));

  assert_write_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel && !rd_wr_n && any_lane) |=> (mode_o == 2'd3 && dq_oe == 16'h0000));
endmodule

bind dwsram_ctl dwsram_chk u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .sel_n     (sel_n),
  .sel_hi    (sel_hi),
  .oe_n      (oe_n),
  .rd_wr_n   (rd_wr_n),
  .lane_lo_n (lane_lo_n),
  .lane_hi_n (lane_hi_n),
  .word_mode (word_mode),
  .dq_oe     (dq_oe),
  .mode_o    (mode_o)
);

// File: tb/dwsram_ctl_tb.sv
`timescale 1ns/1ps
module dwsram_ctl_tb;
  localparam int DEPTH  = 256;
  localparam int ADDR_W = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sel_hi = 1'b0, oe_n = 1'b1, rd_wr_n = 1'b1;
  logic lane_lo_n = 1'b1, lane_hi_n = 1'b1, word_mode = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out, dq_oe;
  logic [1:0]  mode_o;

  always #4 clk = ~clk;

  dwsram_ctl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_hi(sel_hi), .oe_n(oe_n),
    .rd_wr_n(rd_wr_n), .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n),
    .word_mode(word_mode), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .mode_o(mode_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] ref_mem [DEPTH];
  logic [1:0]  q_mode[$];
  logic [15:0] q_dout[$];
  logic [15:0] q_doe[$];
  string       q_tag[$];

  // Driver: applies one cycle of stimulus on the falling edge and queues
  // the outputs that the next rising edge must produce.
  task automatic drive(input logic s_n, input logic s_hi, input logic o_n,
                       input logic rw, input logic lo_n, input logic hi_n,
                       input logic wm, input logic [ADDR_W-1:0] a,
                       input logic [15:0] d, input string tag);
    logic        sel;
    logic [1:0]  lanes;
    logic [1:0]  m;
    logic [15:0] eo, ee, w;
    int          ix;
    @(negedge clk);
    sel_n = s_n; sel_hi = s_hi; oe_n = o_n; rd_wr_n = rw;
    lane_lo_n = lo_n; lane_hi_n = hi_n; word_mode = wm; addr = a; dq_in = d;
    sel   = !s_n && s_hi;
    ix    = int'(a) % DEPTH;
    lanes = wm ? {!hi_n, !lo_n} : (d[15] ? 2'b10 : 2'b01);
    eo = '0; ee = '0; m = 2'd0;
    if (sel && lanes != 2'b00) begin
      if (!rw) begin
        m = 2'd3;
        w = ref_mem[ix];
        if (wm) begin
          if (lanes[0]) w[7:0]  = d[7:0];
          if (lanes[1]) w[15:8] = d[15:8];
        end else if (d[15]) w[15:8] = d[7:0];
        else                w[7:0]  = d[7:0];
        ref_mem[ix] = w;
      end else if (o_n) begin
        m = 2'd1;
      end else begin
        m = 2'd2;
        if (wm) begin
          if (lanes[0]) begin eo[7:0]  = ref_mem[ix][7:0];  ee[7:0]  = 8'hFF; end
          if (lanes[1]) begin eo[15:8] = ref_mem[ix][15:8]; ee[15:8] = 8'hFF; end
        end else begin
          eo[7:0] = d[15] ? ref_mem[ix][15:8] : ref_mem[ix][7:0];
          ee      = 16'h00FF;
        end
      end
    end
    q_mode.push_back(m); q_dout.push_back(eo); q_doe.push_back(ee); q_tag.push_back(tag);
  endtask

  task automatic wr16(input logic [ADDR_W-1:0] a, input logic [15:0] d, input string tag);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, a, d, tag);
  endtask
  task automatic rd16(input logic [ADDR_W-1:0] a, input string tag);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, a, 16'h0000, tag);
  endtask

  // Monitor: one queued expectation per cycle, 2 ns after the rising edge.
  always @(posedge clk) begin
    #2;
    if (q_mode.size() > 0) begin
      logic [1:0]  m;
      logic [15:0] eo, ee;
      string       t;
      m = q_mode.pop_front(); eo = q_dout.pop_front();
      ee = q_doe.pop_front(); t = q_tag.pop_front();
      checks++;
      if (mode_o !== m || dq_out !== eo || dq_oe !== ee) begin
        errors++;
        $display("FAIL %s: mode=%0d dout=%h doe=%h, expected mode=%0d dout=%h doe=%h",
                 t, mode_o, dq_out, dq_oe, m, eo, ee);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    #2;
    checks++;  // R1: state while reset is held
    if (dq_oe !== 16'h0 || dq_out !== 16'h0 || mode_o !== 2'd0) begin
      errors++;
      $display("FAIL R1: mode=%0d dout=%h doe=%h, expected 0 0000 0000", mode_o, dq_out, dq_oe);
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Initialize the words used below so every read has a known value.
    for (int i = 0; i < 8; i++) wr16(ADDR_W'(i), 16'h0000, "R5 init");
    wr16(19'd5, 16'hA55A, "R9 write with oe_n low");
    rd16(19'd5, "R11 read right after write");
    rd16(19'd5, "R4 both lanes");
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 19'd5, 16'h1234, "R5 low-lane write, R9 oe_n high");
    rd16(19'd5, "R5 masked write readback");
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 19'd5, 16'h0, "R4 high lane only");
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 19'd5, 16'h0, "R4 low lane only");
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 19'd5, 16'h0, "R3 output deselect");
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 19'd5, 16'hFFFF, "R2 sel_n high write");
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 19'd5, 16'hEEEE, "R2 sel_hi low write");
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 19'd5, 16'h0, "R2 unselected read");
    rd16(19'd5, "R2 array untouched");
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 19'd5, 16'hDDDD, "R6 no lane write");
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 19'd5, 16'h0, "R6 no lane read");
    rd16(19'd5, "R6 array untouched");
    // Byte mode: dq_in[15] picks the byte; lane enables held high to show they are ignored.
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 19'd5, 16'h8077, "R7 byte write high");
    rd16(19'd5, "R7 byte lands in high lane");
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 19'd5, 16'h0099, "R7 byte write low");
    rd16(19'd5, "R7 byte lands in low lane");
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 19'd5, 16'h8000, "R8 byte read high");
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 19'd5, 16'h0000, "R8 byte read low");
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 19'd5, 16'h8000, "R3 byte deselect");
    // Address wrap
    wr16(19'd261, 16'hBEEF, "R10 write above depth");
    rd16(19'd5, "R10 wrapped readback");
    wr16(19'h40007, 16'hC0DE, "R10 write with top bit set");
    rd16(19'd7, "R10 wrapped readback top bit");
    // Back-to-back traffic over several words
    for (int i = 0; i < 8; i++) wr16(ADDR_W'(i * 37 + 16), 16'(i * 16'h1111) ^ 16'h5A5A, "R11 burst write");
    for (int i = 0; i < 8; i++) rd16(ADDR_W'(i * 37 + 16), "R11 burst readback");
    for (int i = 0; i < 4; i++) begin
      wr16(ADDR_W'(100 + i), 16'h0F0F + 16'(i), "R5 alternating write");
      rd16(ADDR_W'(100 + i), "R11 alternating read");
    end

    @(negedge clk);
    sel_n = 1'b1; sel_hi = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule